// File: doc/BRIEF.md
# Register-Mapped Watchdog with Read-Side Stop

This block is a supervisory countdown kept inside a small byte-wide register file. Software arms it by setting an enable bit and a reset-routing bit in a control register and choosing one of several tick strobes. It then writes a nonzero number of ticks into a count register. Each selected tick decrements the count. If the count runs out, an active-low reset output is pulsed for a fixed number of system clocks. After that the watchdog stays idle until it is loaded again. Software keeps the system alive by rewriting the timeout before it runs out. Writing zero stops the countdown.

The block has one unusual side effect. Reading a neighbouring control/status byte clears the count register, which silently disarms the watchdog. Drivers must therefore rewrite the timeout after every access to that byte. Register reads are registered: the data appears on `rdata` in the cycle after `rd_en`. Three register addresses are parameters, with defaults of 0x01 for the status byte, 0x10 for control and 0x11 for the count.

Top module: `wdr_top`

## Requirements
- R1: After reset the count, control and status registers read as zero, `rdata` is zero and `reset_out_n` is high.
- R2: The control register keeps bit 7 (count enable), bit 6 (route expiry to reset) and bits 1:0 (tick select, where code k picks `tick_in[k]`). Bits 5:2 always read as zero.
- R3: A write of a nonzero value N to the count register loads N, and a later read returns the live remaining count. Rewriting the timeout before expiry restarts the countdown from the written value.
- R4: While the enable bit is set and the count is nonzero, each cycle with the selected tick strobe high lowers the count by one. Strobes on unselected tick inputs, and any strobe while the enable bit is clear, leave the count unchanged.
- R5: Writing zero to the count register stops the watchdog. The count stays zero under further ticks and `reset_out_n` stays high.
- R6: A read of the status byte returns its stored value and also clears the count register to zero, which stops the watchdog. The status byte is otherwise a plain read/write byte.
- R7: When a selected tick takes the count from 1 to 0 with the route bit set, `reset_out_n` goes low in the next cycle for exactly PULSE_LEN (default 4) clocks. The count then stays at zero until it is reloaded.
- R8: If the route bit is clear, an expiry leaves `reset_out_n` high.
- R9: A count-register write in the same cycle as a selected tick loads the written value, and no decrement happens in that cycle. An expiry is then suppressed.
- R10: When `wr_en` and `rd_en` are both high, only the write takes place: there is no read side effect. Addresses outside the three registers read as zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Register address |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data, valid the cycle after `rd_en` |
| tick_in | input | N_TICK | Candidate tick strobes, one clock wide |
| reset_out_n | output | 1 | Active-low timeout reset pulse |

## Verification
Several properties are checked on every cycle:
- the decrement step on a selected tick;
- the priority of a count write over a tick;
- the clear caused by a status read;
- a stopped count staying at zero;
- the start of the reset pulse after a 1-to-0 step, its routing gate and its maximum width.

Only the bench scenarios can show the following:
- the read-back encodings of the control register;
- the fact that unselected tick inputs have no effect, across every select code;
- the exact pulse length for a sweep of load values;
- the keepalive restart;
- the inert unmapped addresses.

// File: rtl/wdr_pkg.sv
package wdr_pkg;
   localparam int unsigned CTL_EN_OFS    = 1;  // offset from MSB
   localparam int unsigned CTL_ROUTE_OFS = 2;  // offset from MSB

   typedef enum logic [1:0] {
      ACC_IDLE  = 2'd0,
      ACC_WRITE = 2'd1,
      ACC_READ  = 2'd2
   } acc_kind_e;

   function automatic acc_kind_e decode_access(input logic wr, input logic rd);
      if (wr)      return ACC_WRITE;
      else if (rd) return ACC_READ;
      else         return ACC_IDLE;
   endfunction
endpackage

// File: rtl/wdr_tick_sel.sv
module wdr_tick_sel #(
   parameter int N_TICK = 4,
   parameter int SEL_W  = 2
) (
   input  logic [N_TICK-1:0] tick_in,
   input  logic [SEL_W-1:0]  sel,
   output logic              tick_hit
);
   generate
      if (N_TICK == 1) begin : g_single
         logic unused_sel;
         assign unused_sel = ^sel;
         assign tick_hit   = tick_in[0];
      end else begin : g_mux
         logic [N_TICK-1:0] dec;
         for (genvar i = 0; i < N_TICK; i++) begin : g_dec
            assign dec[i] = (sel == SEL_W'(i)) && tick_in[i];
         end
         assign tick_hit = |dec;
      end
   endgenerate
endmodule

// File: rtl/wdr_count.sv
module wdr_count #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         clear,
   input  logic         step,
   output logic [W-1:0] cnt,
   output logic         expire
);
   localparam logic [W-1:0] ONE = W'(1);

   logic [W-1:0] cnt_q;
   logic         live;

   assign live   = (cnt_q != '0);
   assign expire = step && !load && !clear && (cnt_q == ONE);
   assign cnt    = cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           cnt_q <= '0;
      else if (load)        cnt_q <= load_val;
      else if (clear)       cnt_q <= '0;
      else if (step && live) cnt_q <= cnt_q - ONE;
   end
endmodule

// File: rtl/wdr_rst_pulse.sv
module wdr_rst_pulse #(
   parameter int LEN = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic pulse_n
);
   localparam int CW = $clog2(LEN + 1);
   localparam logic [CW-1:0] LEN_C = CW'(LEN);

   logic [CW-1:0] left_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              left_q <= '0;
      else if (start)          left_q <= LEN_C;
      else if (left_q != '0)   left_q <= left_q - CW'(1);
   end

   assign pulse_n = (left_q == '0);
endmodule

// File: rtl/wdr_top.sv
module wdr_top #(
   parameter int DATA_W    = 8,
   parameter int ADDR_W    = 8,
   parameter int N_TICK    = 4,
   parameter int PULSE_LEN = 4,
   parameter logic [ADDR_W-1:0] ADR_CLR = 'h01,
   parameter logic [ADDR_W-1:0] ADR_CTL = 'h10,
   parameter logic [ADDR_W-1:0] ADR_VAL = 'h11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   input  logic [N_TICK-1:0] tick_in,
   output logic              reset_out_n
);
   import wdr_pkg::*;

   localparam int SEL_W    = (N_TICK > 1) ? $clog2(N_TICK) : 1;
   localparam int EN_BIT   = DATA_W - CTL_EN_OFS;
   localparam int ROUTE_BIT = DATA_W - CTL_ROUTE_OFS;

   generate
      if (DATA_W < SEL_W + 2) begin : g_bad_width
         $error("DATA_W too small for control fields");
      end
      if (PULSE_LEN < 1) begin : g_bad_pulse
         $error("PULSE_LEN must be at least 1");
      end
      if ((ADR_CLR == ADR_CTL) || (ADR_CLR == ADR_VAL) || (ADR_CTL == ADR_VAL)) begin : g_bad_map
         $error("register addresses must differ");
      end
   endgenerate

   acc_kind_e   acc;
   logic        wr_val, wr_ctl, wr_clr, rd_any, rd_clr;
   logic        ctl_en, ctl_route;
   logic [SEL_W-1:0]  ctl_sel;
   logic [DATA_W-1:0] stat_q;
   logic [DATA_W-1:0] cnt;
   logic [DATA_W-1:0] ctl_view;
   logic [DATA_W-1:0] rd_mux;
   logic        tick_hit;
   logic        expire;

   assign acc    = decode_access(wr_en, rd_en);
   assign wr_val = (acc == ACC_WRITE) && (addr == ADR_VAL);
   assign wr_ctl = (acc == ACC_WRITE) && (addr == ADR_CTL);
   assign wr_clr = (acc == ACC_WRITE) && (addr == ADR_CLR);
   assign rd_any = (acc == ACC_READ);
   assign rd_clr = rd_any && (addr == ADR_CLR);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_en    <= 1'b0;
         ctl_route <= 1'b0;
         ctl_sel   <= '0;
      end else if (wr_ctl) begin
         ctl_en    <= wdata[EN_BIT];
         ctl_route <= wdata[ROUTE_BIT];
         ctl_sel   <= wdata[SEL_W-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      stat_q <= '0;
      else if (wr_clr) stat_q <= wdata;
   end

   always_comb begin
      ctl_view            = '0;
      ctl_view[EN_BIT]    = ctl_en;
      ctl_view[ROUTE_BIT] = ctl_route;
      ctl_view[SEL_W-1:0] = ctl_sel;
   end

   always_comb begin
      if (addr == ADR_VAL)      rd_mux = cnt;
      else if (addr == ADR_CTL) rd_mux = ctl_view;
      else if (addr == ADR_CLR) rd_mux = stat_q;
      else                      rd_mux = '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      rdata <= '0;
      else if (rd_any) rdata <= rd_mux;
   end

   wdr_tick_sel #(.N_TICK(N_TICK), .SEL_W(SEL_W)) u_tick (
      .tick_in  (tick_in),
      .sel      (ctl_sel),
      .tick_hit (tick_hit)
   );

   wdr_count #(.W(DATA_W)) u_count (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (wr_val),
      .load_val (wdata),
      .clear    (rd_clr),
      .step     (ctl_en && tick_hit),
      .cnt      (cnt),
      .expire   (expire)
   );

   wdr_rst_pulse #(.LEN(PULSE_LEN)) u_pulse (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (expire && ctl_route),
      .pulse_n (reset_out_n)
   );
endmodule

// File: rtl/wdr_chk.sv
module wdr_chk #(
   parameter int DATA_W    = 8,
   parameter int ADDR_W    = 8,
   parameter int PULSE_LEN = 4,
   parameter logic [ADDR_W-1:0] ADR_CLR = 'h01,
   parameter logic [ADDR_W-1:0] ADR_VAL = 'h11
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic              rd_en,
   input logic [ADDR_W-1:0] addr,
   input logic [DATA_W-1:0] wdata,
   input logic              tick_hit,
   input logic              ctl_en,
   input logic              ctl_route,
   input logic [DATA_W-1:0] cnt,
   input logic              reset_out_n
);
   localparam int LW = $clog2(PULSE_LEN + 2) + 1;

   logic wv, rc, quiet;
   logic [LW-1:0] low_run;

   assign wv    = wr_en && (addr == ADR_VAL);
   assign rc    = rd_en && !wr_en && (addr == ADR_CLR);
   assign quiet = !wv && !rc;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            low_run <= '0;
      else if (!reset_out_n) low_run <= low_run + LW'(1);
      else                   low_run <= '0;
   end

   a_r4_step_down: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_en && tick_hit && quiet && cnt != '0) |=> (cnt == $past(cnt) - DATA_W'(1)));

   a_r9_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
      wv |=> (cnt == $past(wdata)));

   a_r6_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
      rc |=> (cnt == '0));

   a_r5_zero_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt == '0 && !wv) |=> (cnt == '0));

   a_r7_pulse_begins: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_en && ctl_route && tick_hit && quiet && cnt == DATA_W'(1)) |=> !reset_out_n);

   a_r8_route_gate: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(reset_out_n) |-> ($past(ctl_route) && $past(cnt) == DATA_W'(1)));

   a_r7_pulse_width: assert property (@(posedge clk) disable iff (!rst_n)
      low_run <= LW'(PULSE_LEN));
endmodule

bind wdr_top wdr_chk #(
   .DATA_W(DATA_W), .ADDR_W(ADDR_W), .PULSE_LEN(PULSE_LEN),
   .ADR_CLR(ADR_CLR), .ADR_VAL(ADR_VAL)
) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
   .wdata(wdata), .tick_hit(tick_hit), .ctl_en(ctl_en), .ctl_route(ctl_route),
   .cnt(cnt), .reset_out_n(reset_out_n)
);

// File: tb/wdr_top_tb.sv
module wdr_top_tb;
   localparam logic [7:0] A_CLR = 8'h01;
   localparam logic [7:0] A_CTL = 8'h10;
   localparam logic [7:0] A_VAL = 8'h11;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0, rd_en = 1'b0;
   logic [7:0] addr = '0, wdata = '0;
   logic [7:0] rdata;
   logic [3:0] tick_in = '0;
   logic       reset_out_n;

   int n_tests = 0, n_fail = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   wdr_top u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .wdata(wdata), .rdata(rdata), .tick_in(tick_in), .reset_out_n(reset_out_n)
   );

   task automatic check(input string tag, input int act, input int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk); wr_en = 1; addr = a; wdata = d;
      @(negedge clk); wr_en = 0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [7:0] d);
      @(negedge clk); rd_en = 1; addr = a;
      @(negedge clk); rd_en = 0; d = rdata;
   endtask

   task automatic tick(input int s);
      @(negedge clk); tick_in = 4'(1 << s);
      @(negedge clk); tick_in = '0;
   endtask

   task automatic expect_val(input string tag, input int exp);
      logic [7:0] d;
      rd(A_VAL, d);
      check(tag, d, exp);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_tests++; n_fail++;
         $display("FAIL watchdog timeout actual=hung expected=finish");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      logic [7:0] d;
      int exp, low;
      int loads[5] = '{1, 2, 3, 7, 255};
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1 reset_out_n", reset_out_n, 1);
      check("R1 rdata", rdata, 0);
      rst_n = 1;
      expect_val("R1 count", 0);
      rd(A_CTL, d); check("R1 ctl", d, 0);
      rd(A_CLR, d); check("R1 status", d, 0);

      // R2 control field read-back
      wr(A_CTL, 8'hFF); rd(A_CTL, d); check("R2 ctl ff", d, 8'hC3);
      wr(A_CTL, 8'h3C); rd(A_CTL, d); check("R2 ctl 3c", d, 8'h00);
      wr(A_CTL, 8'h82); rd(A_CTL, d); check("R2 ctl 82", d, 8'h82);

      // R4 sweep every select code against every tick input
      for (int s = 0; s < 4; s++) begin
         wr(A_CTL, 8'(8'h80 | s));
         wr(A_VAL, 8'd20);
         exp = 20;
         for (int t = 0; t < 4; t++) begin
            tick(t);
            if (t == s) exp--;
            expect_val($sformatf("R4 sel%0d tick%0d", s, t), exp);
         end
         wr(A_CTL, 8'(s));
         tick(s);
         expect_val($sformatf("R4 disabled sel%0d", s), exp);
      end

      // R3 / R7 sweep of load values to expiry
      for (int i = 0; i < 5; i++) begin
         wr(A_CTL, 8'hC2);
         wr(A_VAL, 8'(loads[i]));
         expect_val($sformatf("R3 load %0d", loads[i]), loads[i]);
         for (int k = 1; k < loads[i]; k++) tick(2);
         expect_val($sformatf("R4 before expiry %0d", loads[i]), 1);
         check("R7 high before expiry", reset_out_n, 1);
         tick(2);
         low = 0;
         while (!reset_out_n && low < 50) begin low++; @(negedge clk); end
         check($sformatf("R7 pulse length load %0d", loads[i]), low, 4);
         tick(2);
         expect_val("R7 stays stopped", 0);
         check("R7 no second pulse", reset_out_n, 1);
      end

      // R3 keepalive restart
      wr(A_VAL, 8'd10);
      repeat (3) tick(2);
      expect_val("R3 after 3 ticks", 7);
      wr(A_VAL, 8'd10);
      expect_val("R3 keepalive", 10);

      // R5 zero write stops
      wr(A_VAL, 8'd0);
      for (int k = 0; k < 5; k++) begin
         tick(2);
         check("R5 no pulse", reset_out_n, 1);
      end
      expect_val("R5 stays zero", 0);

      // R8 route bit clear
      wr(A_CTL, 8'h82);
      wr(A_VAL, 8'd1);
      tick(2);
      check("R8 high at expiry", reset_out_n, 1);
      @(negedge clk);
      check("R8 high after", reset_out_n, 1);
      expect_val("R8 count zero", 0);

      // R6 status read clears count
      wr(A_CTL, 8'hC2);
      wr(A_CLR, 8'h5A);
      wr(A_VAL, 8'd40);
      rd(A_CLR, d); check("R6 status value", d, 8'h5A);
      expect_val("R6 count cleared", 0);
      repeat (3) tick(2);
      expect_val("R6 still stopped", 0);
      check("R6 no pulse", reset_out_n, 1);

      // R9 write beats simultaneous tick
      wr(A_VAL, 8'd30);
      @(negedge clk); wr_en = 1; addr = A_VAL; wdata = 8'd77; tick_in = 4'b0100;
      @(negedge clk); wr_en = 0; tick_in = '0;
      expect_val("R9 write wins", 77);
      wr(A_VAL, 8'd1);
      @(negedge clk); wr_en = 1; addr = A_VAL; wdata = 8'd9; tick_in = 4'b0100;
      @(negedge clk); wr_en = 0; tick_in = '0;
      check("R9 expiry suppressed", reset_out_n, 1);
      expect_val("R9 reload value", 9);

      // R10 unmapped address and write+read collision
      wr(8'h05, 8'hAA);
      rd(8'h05, d); check("R10 unmapped reads zero", d, 0);
      wr(A_VAL, 8'd12);
      @(negedge clk); wr_en = 1; rd_en = 1; addr = A_CLR; wdata = 8'h33;
      @(negedge clk); wr_en = 0; rd_en = 0;
      expect_val("R10 no clear on collision", 12);
      rd(A_CLR, d); check("R10 status written", d, 8'h33);

      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule